// File: doc/BRIEF.md
# Snooping MSI Cache Line Controller

This block keeps one cache coherent with its peers on a shared bus. It holds a coherence state (Modified, Shared or Invalid), an address tag and a one-word data copy for each line of a small direct-mapped store. It serves processor reads, writes and eviction requests, and it watches the transactions that other caches put on the bus.

When a processor request can be served locally, the block completes it in the same cycle. Otherwise it requests the bus and waits for the grant. It then drives a read, read-exclusive or writeback command and holds it until the memory side acknowledges it. The processor is stalled until that transaction has finished.

A snooped read or read-exclusive that hits a dirty line makes the block flush the line to memory on the cycle after the snoop. A read-exclusive also removes any clean copy of the line. Snoop handling always takes priority over processor traffic to the same line.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: cpu_ready is 1 and bus_req, bus_valid and snp_flush are 0, and the first read of any address misses.
- R2: A read (cpu_req_op 0) to a line held Shared or Modified with a matching tag completes in its accept cycle with cpu_hit=1, the line's data on cpu_rdata and no bus transaction. A read miss issues one bus read (bus_op 1), returns bus_rdata, and leaves the line Shared.
- R3: A write (cpu_req_op 1) to a Modified line with a matching tag is a local hit that stores cpu_req_wdata. A write to an Invalid or Shared line issues one read-exclusive (bus_op 2), and the line then becomes Modified holding the written word.
- R4: A snooped read (snp_op 1) that hits a Modified line raises snp_flush for one cycle, one cycle after the snoop, carrying the snooped address and the line's data. The line becomes Shared, so a later read hits and a later write needs a read-exclusive.
- R5: A snooped read-exclusive (snp_op 2) that hits a Modified line flushes as in R4 and leaves the line Invalid. The same snoop on a Shared line makes it Invalid without a flush.
- R6: A snooped read that hits a Shared line, any snoop whose tag differs, and a snooped writeback (snp_op 3) cause no flush and leave the line state unchanged.
- R7: An eviction (cpu_req_op 2, or the unused code 3) of a Modified line with a matching tag issues a writeback (bus_op 3) of its address and data, then leaves the line Invalid with cpu_hit=0. Evicting a Shared line is silent (cpu_hit=1), and a later read of it misses.
- R8: A read or write that maps onto a Modified line with a different tag first writes the victim back (bus_op 3, with the victim's own address and data) and then issues its own fetch. That makes two bus transactions, in that order.
- R9: bus_req stays high until bus_gnt arrives. bus_valid is only driven while bus_gnt is high, and bus_valid holds with a stable bus_op and bus_addr until bus_ack. A request that needs the bus completes with cpu_done in its final bus_ack cycle.
- R10: While snp_valid is high with the same line index as cpu_req_addr, cpu_ready is 0. With a different index cpu_ready is 1.
- R11: A read followed by a write to an address that no cache holds costs exactly two bus transactions: a read, then a read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_op | input | 2 | 0 read, 1 write, 2 evict (3 treated as evict) |
| cpu_req_addr | input | IDX_W+TAG_W | Request address; low IDX_W bits select the line |
| cpu_req_wdata | input | DW | Write data |
| cpu_ready | output | 1 | Request may be accepted this cycle |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | With cpu_done: completed without bus transaction |
| cpu_rdata | output | DW | Read data, valid with cpu_done |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership granted |
| bus_valid | output | 1 | Command driven on bus |
| bus_op | output | 2 | 1 read, 2 read-exclusive, 3 writeback |
| bus_addr | output | IDX_W+TAG_W | Command address |
| bus_wdata | output | DW | Writeback data |
| bus_ack | input | 1 | Command finished |
| bus_rdata | input | DW | Fill data, valid with bus_ack |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 2 | Snooped command, coded as bus_op |
| snp_addr | input | IDX_W+TAG_W | Snooped address |
| snp_flush | output | 1 | Dirty line flushed to memory |
| snp_flush_addr | output | IDX_W+TAG_W | Flushed address |
| snp_flush_data | output | DW | Flushed data |

## Verification
Directed sequences walk one line through every state and every pairing of processor and snoop events. Each one checks for a hit or for the exact sequence of bus commands. This separates a read hit from a needless refetch, a write hit on a Modified line from an upgrade on a Shared one, and a snoop flush from a silent invalidation. Conflict patterns put two tags on one line index, which exposes a missing or misordered victim writeback. The random phase interleaves reads, writes, evictions and snoops over four tags and four lines. Checking every read's data against a bench memory model shows whether a flush or writeback was lost or carried the wrong word.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LS_INV = 2'd0, LS_SHD = 2'd1, LS_MOD = 2'd2} line_st_t;
  typedef enum logic [1:0] {BOP_NONE = 2'd0, BOP_RD = 2'd1, BOP_RDX = 2'd2, BOP_WB = 2'd3} bus_op_t;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_ARB = 2'd1, F_XFER = 2'd2} fsm_t;

  localparam logic [1:0] CREQ_RD = 2'd0;
  localparam logic [1:0] CREQ_WR = 2'd1;

  // bus command a processor request needs, ignoring any victim
  function automatic bus_op_t fetch_op(input logic [1:0] creq, input line_st_t st, input logic tag_eq);
    logic present;
    present = tag_eq && (st != LS_INV);
    case (creq)
      CREQ_RD: fetch_op = present ? BOP_NONE : BOP_RD;
      CREQ_WR: fetch_op = (present && st == LS_MOD) ? BOP_NONE : BOP_RDX;
      default: fetch_op = (present && st == LS_MOD) ? BOP_WB : BOP_NONE;
    endcase
  endfunction

  // a fill would overwrite a dirty line of another tag
  function automatic logic victim_dirty(input logic [1:0] creq, input line_st_t st, input logic tag_eq);
    victim_dirty = (creq == CREQ_RD || creq == CREQ_WR) && st == LS_MOD && !tag_eq;
  endfunction

  function automatic line_st_t snoop_next(input line_st_t st, input logic tag_eq, input bus_op_t sop);
    snoop_next = st;
    if (tag_eq) begin
      if (sop == BOP_RDX) snoop_next = LS_INV;
      else if (sop == BOP_RD && st == LS_MOD) snoop_next = LS_SHD;
    end
  endfunction

  function automatic logic snoop_flush(input line_st_t st, input logic tag_eq, input bus_op_t sop);
    snoop_flush = tag_eq && st == LS_MOD && (sop == BOP_RD || sop == BOP_RDX);
  endfunction
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output line_st_t         ra_st,
  output logic [TAG_W-1:0] ra_tag,
  output logic [DW-1:0]    ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output line_st_t         rb_st,
  output logic [TAG_W-1:0] rb_tag,
  output logic [DW-1:0]    rb_data,
  input  logic             sa_en,
  input  logic [IDX_W-1:0] sa_idx,
  input  line_st_t         sa_st,
  input  logic             pw_en,
  input  logic [IDX_W-1:0] pw_idx,
  input  line_st_t         pw_st,
  input  logic             pw_fill,
  input  logic [TAG_W-1:0] pw_tag,
  input  logic             pw_data_en,
  input  logic [DW-1:0]    pw_data
);
  localparam int NL = 1 << IDX_W;

  line_st_t         st_q   [NL];
  logic [TAG_W-1:0] tag_q  [NL];
  logic [DW-1:0]    data_q [NL];

  for (genvar g = 0; g < NL; g++) begin : g_line
    logic sel_s, sel_p;
    assign sel_s = sa_en && sa_idx == IDX_W'(g);
    assign sel_p = pw_en && pw_idx == IDX_W'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= LS_INV;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else begin
        // snoop updates win over processor-side updates
        if (sel_s) st_q[g] <= sa_st;
        else if (sel_p) st_q[g] <= pw_st;
        if (sel_p && pw_fill) tag_q[g] <= pw_tag;
        if (sel_p && pw_data_en) data_q[g] <= pw_data;
      end
    end
  end

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = data_q[rb_idx];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4,
  parameter int DW    = 8,
  localparam int AW   = IDX_W + TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [AW-1:0]    snp_addr,
  input  line_st_t         ln_st,
  input  logic [TAG_W-1:0] ln_tag,
  input  logic [DW-1:0]    ln_data,
  output logic             upd_en,
  output line_st_t         upd_st,
  output logic             flush_ev,
  output logic             flush,
  output logic [AW-1:0]    flush_addr,
  output logic [DW-1:0]    flush_data
);
  logic    tag_eq;
  bus_op_t sop;

  assign sop      = bus_op_t'(snp_op);
  assign tag_eq   = ln_tag == snp_addr[AW-1:IDX_W];
  assign upd_st   = snoop_next(ln_st, tag_eq, sop);
  assign upd_en   = snp_valid && upd_st != ln_st;
  assign flush_ev = snp_valid && snoop_flush(ln_st, tag_eq, sop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush      <= 1'b0;
      flush_addr <= '0;
      flush_data <= '0;
    end else begin
      flush <= flush_ev;
      if (flush_ev) begin
        flush_addr <= snp_addr;
        flush_data <= ln_data;
      end
    end
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4,
  parameter int DW    = 8,
  localparam int AW   = IDX_W + TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  input  logic [1:0]       cpu_req_op,
  input  logic [AW-1:0]    cpu_req_addr,
  input  logic [DW-1:0]    cpu_req_wdata,
  input  logic             snp_clash,
  output logic             cpu_ready,
  output logic             cpu_done,
  output logic             cpu_hit,
  output logic [DW-1:0]    cpu_rdata,
  output logic [IDX_W-1:0] look_idx,
  input  line_st_t         ln_st,
  input  logic [TAG_W-1:0] ln_tag,
  input  logic [DW-1:0]    ln_data,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             bus_valid,
  output logic [1:0]       bus_op,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ack,
  input  logic [DW-1:0]    bus_rdata,
  output logic             pw_en,
  output line_st_t         pw_st,
  output logic             pw_fill,
  output logic [TAG_W-1:0] pw_tag,
  output logic             pw_data_en,
  output logic [DW-1:0]    pw_data,
  output logic             victim_wb_ev
);
  fsm_t          fs, fs_n;
  logic [1:0]    h_op;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata;
  bus_op_t       x_op, x_op_n;
  logic [AW-1:0] x_addr, x_addr_n;
  logic [DW-1:0] x_data, x_data_n;
  logic          load_h, load_x;

  logic             idle, tag_eq, vdirty, local_ok, accept;
  logic [1:0]       sel_op;
  logic [AW-1:0]    sel_addr;
  logic [DW-1:0]    sel_wdata;
  logic [TAG_W-1:0] sel_tag;
  bus_op_t          need;

  assign idle      = fs == F_IDLE;
  assign sel_op    = idle ? cpu_req_op : h_op;
  assign sel_addr  = idle ? cpu_req_addr : h_addr;
  assign sel_wdata = idle ? cpu_req_wdata : h_wdata;
  assign sel_tag   = sel_addr[AW-1:IDX_W];
  assign look_idx  = sel_addr[IDX_W-1:0];
  assign tag_eq    = ln_tag == sel_tag;
  assign need      = fetch_op(sel_op, ln_st, tag_eq);
  assign vdirty    = victim_dirty(sel_op, ln_st, tag_eq);
  assign local_ok  = need == BOP_NONE && !vdirty;
  assign cpu_ready = idle && !snp_clash;
  assign accept    = cpu_req_valid && cpu_ready;

  assign bus_req   = fs != F_IDLE;
  assign bus_valid = fs == F_XFER;
  assign bus_op    = x_op;
  assign bus_addr  = x_addr;
  assign bus_wdata = x_data;
  assign pw_tag    = sel_tag;

  always_comb begin
    fs_n         = fs;
    load_h       = 1'b0;
    load_x       = 1'b0;
    x_op_n       = x_op;
    x_addr_n     = x_addr;
    x_data_n     = x_data;
    cpu_done     = 1'b0;
    cpu_hit      = 1'b0;
    cpu_rdata    = ln_data;
    pw_en        = 1'b0;
    pw_st        = ln_st;
    pw_fill      = 1'b0;
    pw_data_en   = 1'b0;
    pw_data      = sel_wdata;
    victim_wb_ev = 1'b0;
    case (fs)
      F_IDLE: begin
        if (accept) begin
          if (local_ok) begin
            cpu_done = 1'b1;
            cpu_hit  = 1'b1;
            if (sel_op == CREQ_WR) begin
              pw_en      = 1'b1;
              pw_st      = LS_MOD;
              pw_data_en = 1'b1;
            end else if (sel_op != CREQ_RD && tag_eq && ln_st != LS_INV) begin
              pw_en = 1'b1;
              pw_st = LS_INV;
            end
          end else begin
            fs_n   = F_ARB;
            load_h = 1'b1;
          end
        end
      end
      F_ARB: begin
        if (bus_gnt) begin
          if (vdirty) begin
            x_op_n   = BOP_WB;
            x_addr_n = {ln_tag, look_idx};
            x_data_n = ln_data;
            load_x   = 1'b1;
            fs_n     = F_XFER;
          end else if (need != BOP_NONE) begin
            x_op_n   = need;
            x_addr_n = h_addr;
            x_data_n = (need == BOP_WB) ? ln_data : h_wdata;
            load_x   = 1'b1;
            fs_n     = F_XFER;
          end else begin
            // a snoop already cleaned the line meanwhile: finish locally
            cpu_done = 1'b1;
            cpu_hit  = 1'b1;
            fs_n     = F_IDLE;
            if (sel_op != CREQ_RD && sel_op != CREQ_WR && tag_eq && ln_st != LS_INV) begin
              pw_en = 1'b1;
              pw_st = LS_INV;
            end
          end
        end
      end
      F_XFER: begin
        if (bus_ack) begin
          pw_en = 1'b1;
          case (x_op)
            BOP_WB: begin
              pw_st = LS_INV;
              if (h_op == CREQ_RD || h_op == CREQ_WR) begin
                victim_wb_ev = 1'b1;
                fs_n         = F_ARB;
              end else begin
                cpu_done = 1'b1;
                fs_n     = F_IDLE;
              end
            end
            BOP_RD: begin
              pw_st      = LS_SHD;
              pw_fill    = 1'b1;
              pw_data_en = 1'b1;
              pw_data    = bus_rdata;
              cpu_rdata  = bus_rdata;
              cpu_done   = 1'b1;
              fs_n       = F_IDLE;
            end
            default: begin
              pw_st      = LS_MOD;
              pw_fill    = 1'b1;
              pw_data_en = 1'b1;
              pw_data    = h_wdata;
              cpu_done   = 1'b1;
              fs_n       = F_IDLE;
            end
          endcase
        end
      end
      default: fs_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs      <= F_IDLE;
      h_op    <= '0;
      h_addr  <= '0;
      h_wdata <= '0;
      x_op    <= BOP_NONE;
      x_addr  <= '0;
      x_data  <= '0;
    end else begin
      fs <= fs_n;
      if (load_h) begin
        h_op    <= cpu_req_op;
        h_addr  <= cpu_req_addr;
        h_wdata <= cpu_req_wdata;
      end
      if (load_x) begin
        x_op   <= x_op_n;
        x_addr <= x_addr_n;
        x_data <= x_data_n;
      end
    end
  end
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4,
  parameter int DW    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req_valid,
  input  logic [1:0]             cpu_req_op,
  input  logic [IDX_W+TAG_W-1:0] cpu_req_addr,
  input  logic [DW-1:0]          cpu_req_wdata,
  output logic                   cpu_ready,
  output logic                   cpu_done,
  output logic                   cpu_hit,
  output logic [DW-1:0]          cpu_rdata,
  output logic                   bus_req,
  input  logic                   bus_gnt,
  output logic                   bus_valid,
  output logic [1:0]             bus_op,
  output logic [IDX_W+TAG_W-1:0] bus_addr,
  output logic [DW-1:0]          bus_wdata,
  input  logic                   bus_ack,
  input  logic [DW-1:0]          bus_rdata,
  input  logic                   snp_valid,
  input  logic [1:0]             snp_op,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  output logic                   snp_flush,
  output logic [IDX_W+TAG_W-1:0] snp_flush_addr,
  output logic [DW-1:0]          snp_flush_data
);
  localparam int AW = IDX_W + TAG_W;

  logic [IDX_W-1:0] look_idx;
  line_st_t         ra_st, rb_st, sa_st, pw_st;
  logic [TAG_W-1:0] ra_tag, rb_tag, pw_tag;
  logic [DW-1:0]    ra_data, rb_data, pw_data;
  logic             sa_en, pw_en, pw_fill, pw_data_en;
  logic             snp_clash;
  logic             ev_victim_wb;
  logic             ev_snoop_flush;

  assign snp_clash = snp_valid && snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0];

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(look_idx), .ra_st(ra_st), .ra_tag(ra_tag), .ra_data(ra_data),
    .rb_idx(snp_addr[IDX_W-1:0]), .rb_st(rb_st), .rb_tag(rb_tag), .rb_data(rb_data),
    .sa_en(sa_en), .sa_idx(snp_addr[IDX_W-1:0]), .sa_st(sa_st),
    .pw_en(pw_en), .pw_idx(look_idx), .pw_st(pw_st), .pw_fill(pw_fill),
    .pw_tag(pw_tag), .pw_data_en(pw_data_en), .pw_data(pw_data)
  );

  coh_snoop_unit #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .ln_st(rb_st), .ln_tag(rb_tag), .ln_data(rb_data),
    .upd_en(sa_en), .upd_st(sa_st), .flush_ev(ev_snoop_flush),
    .flush(snp_flush), .flush_addr(snp_flush_addr), .flush_data(snp_flush_data)
  );

  coh_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .snp_clash(snp_clash),
    .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .look_idx(look_idx), .ln_st(ra_st), .ln_tag(ra_tag), .ln_data(ra_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .pw_en(pw_en), .pw_st(pw_st), .pw_fill(pw_fill), .pw_tag(pw_tag),
    .pw_data_en(pw_data_en), .pw_data(pw_data),
    .victim_wb_ev(ev_victim_wb)
  );
endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
module coh_snoop_ctrl_chk #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [IDX_W+TAG_W-1:0] cpu_req_addr,
  input logic                   cpu_ready,
  input logic                   cpu_done,
  input logic                   cpu_hit,
  input logic                   bus_req,
  input logic                   bus_gnt,
  input logic                   bus_valid,
  input logic [1:0]             bus_op,
  input logic [IDX_W+TAG_W-1:0] bus_addr,
  input logic                   bus_ack,
  input logic                   snp_valid,
  input logic [IDX_W+TAG_W-1:0] snp_addr,
  input logic                   snp_flush,
  input logic                   ev_victim_wb,
  input logic                   ev_snoop_flush
);
  a_r9_valid_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_gnt);

  a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);

  a_r9_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_op) && $stable(bus_addr));

  a_r2_miss_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && !cpu_hit |-> bus_ack);

  a_r4_flush_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snoop_flush |=> snp_flush);

  a_r4_flush_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> $past(snp_valid));

  a_r8_victim_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ev_victim_wb |=> bus_req && !bus_valid && !cpu_done);

  a_r10_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0] |-> !cpu_ready);
endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_addr(cpu_req_addr), .cpu_ready(cpu_ready),
  .cpu_done(cpu_done), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_valid(bus_valid), .bus_op(bus_op), .bus_addr(bus_addr), .bus_ack(bus_ack),
  .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_flush(snp_flush),
  .ev_victim_wb(ev_victim_wb), .ev_snoop_flush(ev_snoop_flush)
);

// File: tb/sim_coh_snoop_ctrl.sv
module sim_coh_snoop_ctrl;
  localparam int IW = 2;
  localparam int TW = 4;
  localparam int DW = 8;
  localparam int AW = IW + TW;
  localparam int NL = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cpu_req_valid = 1'b0;
  logic [1:0]    cpu_req_op = '0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_ready, cpu_done, cpu_hit;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_valid;
  logic          tb_gnt = 1'b0, tb_ack = 1'b0;
  logic [1:0]    bus_op;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_op = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_flush;
  logic [AW-1:0] snp_flush_addr;
  logic [DW-1:0] snp_flush_data;

  coh_snoop_ctrl #(.IDX_W(IW), .TAG_W(TW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_op(cpu_req_op), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_ready(cpu_ready), .cpu_done(cpu_done),
    .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(tb_gnt), .bus_valid(bus_valid), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(tb_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_flush_addr(snp_flush_addr), .snp_flush_data(snp_flush_data)
  );

  // bus memory and arbiter
  logic [DW-1:0] mem [1 << AW];
  logic [1:0]    seen_ops [64];
  int            n_seen = 0;
  int            hs_viol = 0;
  logic [AW-1:0] last_wb_addr = '0;
  logic [DW-1:0] last_wb_data = '0;

  assign bus_rdata = mem[bus_addr];

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 3);

  always @(posedge clk) begin
    if (!rst_n) begin
      tb_gnt <= 1'b0;
      tb_ack <= 1'b0;
    end else begin
      tb_gnt <= bus_req;
      tb_ack <= bus_valid && !tb_ack;
      if (bus_valid && !tb_gnt) hs_viol <= hs_viol + 1;
      if (tb_ack) begin
        seen_ops[n_seen % 64] <= bus_op;
        n_seen <= n_seen + 1;
        if (bus_op == 2'd3) begin
          mem[bus_addr] <= bus_wdata;
          last_wb_addr  <= bus_addr;
          last_wb_data  <= bus_wdata;
        end
      end
      if (snp_flush) mem[snp_flush_addr] <= snp_flush_data;
    end
  end

  // reference model: 0 Invalid, 1 Shared, 2 Modified
  logic [1:0]    rs [NL];
  logic [TW-1:0] rt [NL];
  logic [DW-1:0] rd [NL];
  logic [DW-1:0] rm [1 << AW];

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input string rq, input logic [1:0] op, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd);
    logic [IW-1:0] idx;
    logic [TW-1:0] tg;
    logic          m, vd, ex_hit;
    int            ex_n, base, guard;
    logic [1:0]    ex_op0, ex_op1;
    logic [DW-1:0] ex_rd, got_rd;
    logic [AW-1:0] ex_wb_addr;
    logic [DW-1:0] ex_wb_data;
    logic          got_hit;
    idx = addr[IW-1:0];
    tg  = addr[AW-1:IW];
    m   = rs[idx] != 2'd0 && rt[idx] == tg;
    vd  = rs[idx] == 2'd2 && rt[idx] != tg;
    ex_n = 0; ex_op0 = 0; ex_op1 = 0; ex_rd = rd[idx];
    ex_wb_addr = last_wb_addr; ex_wb_data = last_wb_data;
    if (op == 2'd0 || op == 2'd1) begin
      if (!(m && (op == 2'd0 || rs[idx] == 2'd2))) begin
        if (vd) begin
          ex_n = 2; ex_op0 = 2'd3; ex_op1 = (op == 2'd0) ? 2'd1 : 2'd2;
          ex_wb_addr = {rt[idx], idx}; ex_wb_data = rd[idx];
          rm[{rt[idx], idx}] = rd[idx];
        end else begin
          ex_n = 1; ex_op0 = (op == 2'd0) ? 2'd1 : 2'd2;
        end
      end
      if (ex_n != 0) begin
        ex_rd = rm[addr];
        rs[idx] = (op == 2'd0) ? 2'd1 : 2'd2;
        rt[idx] = tg;
        rd[idx] = (op == 2'd0) ? rm[addr] : wd;
      end else if (op == 2'd1) begin
        rd[idx] = wd;
      end
    end else begin
      if (m && rs[idx] == 2'd2) begin
        ex_n = 1; ex_op0 = 2'd3;
        ex_wb_addr = addr; ex_wb_data = rd[idx];
        rm[addr] = rd[idx];
      end
      if (m) rs[idx] = 2'd0;
    end
    ex_hit = ex_n == 0;
    base = n_seen;

    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = addr; cpu_req_wdata = wd;
    #1;
    if (cpu_done) begin
      got_hit = cpu_hit; got_rd = cpu_rdata;
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
    end else begin
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      guard = 0;
      while (!cpu_done && guard < 200) begin
        @(negedge clk);
        guard++;
      end
      got_hit = cpu_hit; got_rd = cpu_rdata;
      if (guard >= 200) chk(rq, "completion timeout", 0, 1);
      @(posedge clk);
      @(negedge clk);
    end
    chk(rq, "cpu_hit", 32'(got_hit), 32'(ex_hit));
    if (op == 2'd0) chk(rq, "cpu_rdata", 32'(got_rd), 32'(ex_rd));
    chk(rq, "bus transaction count", 32'(n_seen - base), 32'(ex_n));
    if (ex_n >= 1) chk(rq, "first bus op", 32'(seen_ops[base % 64]), 32'(ex_op0));
    if (ex_n >= 2) chk(rq, "second bus op", 32'(seen_ops[(base + 1) % 64]), 32'(ex_op1));
    if (ex_op0 == 2'd3) begin
      chk(rq, "writeback addr", 32'(last_wb_addr), 32'(ex_wb_addr));
      chk(rq, "writeback data", 32'(last_wb_data), 32'(ex_wb_data));
    end
  endtask

  task automatic do_snoop(input string rq, input logic [1:0] op, input logic [AW-1:0] addr);
    logic [IW-1:0] idx;
    logic          m, ex_fl;
    logic [DW-1:0] ex_d;
    idx = addr[IW-1:0];
    m = rs[idx] != 2'd0 && rt[idx] == addr[AW-1:IW];
    ex_fl = m && rs[idx] == 2'd2 && (op == 2'd1 || op == 2'd2);
    ex_d = rd[idx];
    if (ex_fl) rm[addr] = rd[idx];
    if (m && op == 2'd2) rs[idx] = 2'd0;
    else if (ex_fl) rs[idx] = 2'd1;
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = addr;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    chk(rq, "snp_flush", 32'(snp_flush), 32'(ex_fl));
    if (ex_fl) begin
      chk(rq, "snp_flush_addr", 32'(snp_flush_addr), 32'(addr));
      chk(rq, "snp_flush_data", 32'(snp_flush_data), 32'(ex_d));
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NL; i++) begin rs[i] = 0; rt[i] = 0; rd[i] = 0; end
    for (int i = 0; i < (1 << AW); i++) rm[i] = DW'(i * 7 + 3);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "cpu_ready", 32'(cpu_ready), 1);
    chk("R1", "bus_req", 32'(bus_req), 0);
    chk("R1", "bus_valid", 32'(bus_valid), 0);
    chk("R1", "snp_flush", 32'(snp_flush), 0);
    do_req("R1", 2'd0, 6'h05, 8'h00);           // first read misses
    do_req("R2", 2'd0, 6'h05, 8'h00);           // read hit on Shared
    do_req("R3", 2'd1, 6'h05, 8'hA1);           // upgrade Shared -> Modified
    do_req("R3", 2'd1, 6'h05, 8'hA2);           // write hit on Modified
    do_req("R2", 2'd0, 6'h05, 8'h00);           // read hit on Modified
    do_snoop("R4", 2'd1, 6'h05);                // flush, drop to Shared
    do_req("R4", 2'd0, 6'h05, 8'h00);           // still readable
    do_req("R4", 2'd1, 6'h05, 8'hB3);           // needs read-exclusive again
    do_snoop("R5", 2'd2, 6'h05);                // flush, Invalid
    do_req("R5", 2'd0, 6'h05, 8'h00);           // misses, sees flushed data
    do_snoop("R5", 2'd2, 6'h05);                // Shared -> Invalid silently
    do_req("R5", 2'd0, 6'h05, 8'h00);
    do_snoop("R6", 2'd1, 6'h05);                // read on Shared: no change
    do_req("R6", 2'd0, 6'h05, 8'h00);
    do_req("R6", 2'd1, 6'h06, 8'hC4);           // line 2 Modified
    do_snoop("R6", 2'd2, 6'h0A);                // other tag: ignored
    do_snoop("R6", 2'd3, 6'h06);                // foreign writeback: ignored
    do_req("R6", 2'd1, 6'h06, 8'hC5);           // still a hit
    do_req("R7", 2'd2, 6'h06, 8'h00);           // evict Modified: writeback
    do_req("R7", 2'd0, 6'h06, 8'h00);           // then misses
    do_req("R7", 2'd2, 6'h06, 8'h00);           // evict Shared: silent
    do_req("R7", 2'd0, 6'h06, 8'h00);           // then misses
    do_req("R8", 2'd1, 6'h13, 8'hD6);           // line 3 Modified
    do_req("R8", 2'd0, 6'h27, 8'h00);           // conflict: wb then read
    do_req("R8", 2'd1, 6'h13, 8'hD7);           // Shared victim: just read-exclusive
    do_req("R8", 2'd1, 6'h27, 8'hD8);           // Modified victim: wb then rdx
    do_req("R11", 2'd0, 6'h3C, 8'h00);          // absent line read
    do_req("R11", 2'd1, 6'h3C, 8'hE9);          // then write
    // R10 snoop priority on cpu_ready
    @(negedge clk);
    cpu_req_addr = 6'h09; snp_valid = 1'b1; snp_op = 2'd3; snp_addr = 6'h31;
    #1 chk("R10", "cpu_ready same index", 32'(cpu_ready), 0);
    snp_addr = 6'h32;
    #1 chk("R10", "cpu_ready other index", 32'(cpu_ready), 1);
    snp_valid = 1'b0;
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      int r;
      a = {TW'($urandom % 4), IW'($urandom % NL)};
      r = $urandom % 10;
      if (r < 6) do_req("R2", 2'($urandom % 3), a, DW'($urandom));
      else do_snoop("R6", 2'(1 + $urandom % 3), a);
    end
    chk("R9", "grant violations", 32'(hs_viol), 0);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule